// File: doc/BRIEF.md
# Data-Processing Execute Stage

This unit runs the register-to-register arithmetic and logic instructions of a 32-register, 32-bit RISC core. Each cycle the surrounding pipeline may present one decoded instruction word together with the values already read for its first source, its second source and its shift-amount register. The unit builds the second operand, runs the selected ALU operation and returns the result for write-back one clock later. It keeps the four condition flags and updates them when the instruction asks for it.

The second operand has three possible sources. It can be a register shifted by a constant, a register shifted by the low bits of another register, or a 9-bit constant rotated left by a 5-bit amount. The two move opcodes have no first source, so their first-source field carries a condition code instead. Such a move writes its destination only when that condition holds against the flags.

Top module: `dp_exec_unit`

## Requirements
- R1: When `in_valid` is high and `instr[31:30]` is 00, then on the next clock `res_valid` is 1, `res_rd` equals `instr[18:14]` and `res_data` holds the ALU result. A cycle with `in_valid` low gives `res_valid` 0 and `res_write` 0 on the next clock.
- R2: When `instr[29]` is 1 (immediate form), the second operand is the zero-extended `instr[8:0]` rotated left by `instr[13:9]`. The shifter carry equals the current C flag.
- R3: When `instr[29]` is 0 and `instr[5]` is 0, `rm_val` is shifted by `instr[13:9]`, and `instr[7:6]` selects the kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. The shifter carry is the last bit shifted out, or bit 31 of the rotated value for rotate right. An amount of 0 passes `rm_val` unchanged and keeps the carry equal to C.
- R4: When `instr[29]` is 0 and `instr[5]` is 1, the shift amount is `rs_val[4:0]` and the upper bits of `rs_val` are ignored. The shift kinds and the zero-amount rule are the same as in R3.
- R5: `instr[28:25]` selects the operation, with a = `rn_val` and b = second operand: 0 a&b, 1 a^b, 2 a-b, 3 b-a, 4 a+b, 5 a+b+C, 6 a-b-!C, 7 b-a-!C, 8 test a&b, 9 test a^b, 10 compare a-b, 11 compare a+b, 12 a|b, 13 b, 14 a&~b, 15 ~b.
- R6: Opcodes 8 to 11 never assert `res_write`.
- R7: `flags_o` = {N,Z,C,V} (bit 3 to bit 0). It changes only on a clock that accepts a valid instruction of class 00x with `instr[24]` set.
- R8: Logical opcodes (0, 1, 8, 9, 12 to 15) set N and Z from the result and C from the shifter carry. They leave V unchanged.
- R9: Arithmetic opcodes (2 to 7, 10, 11) set N and Z from the result, C to the adder carry-out (1 = no borrow for subtraction) and V to the signed overflow.
- R10: For opcodes 13 and 15, `instr[22:19]` is a condition tested against the flags held before the instruction: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 and 15 always. `instr[23]` is ignored. If the condition fails, neither Rd nor the flags are written.
- R11: A synchronous active-high `rst` clears `flags_o`, `res_valid` and `res_write` on the next clock.
- R12: An instruction whose `instr[31:30]` is not 00 is not executed: `res_valid` stays 0 and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | Value of the first-source register |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the shift-amount register |
| res_valid | output | 1 | A data-processing instruction completed |
| res_write | output | 1 | The destination register is to be written |
| res_rd | output | 5 | Destination register index |
| res_data | output | 32 | ALU result |
| flags_o | output | 4 | Condition flags {N,Z,C,V} |

## Verification
Directed cases cover every operand source:
- Constant rotations that wrap past bit 31.
- Each shift kind at amount 0, 1 and large amounts.
- A register-held amount whose upper bits are set, which shows that only its low five bits count.

A sweep of all sixteen opcodes over fixed operands shows the carry and overflow rules on both adder paths. Running a logical operation right after an overflow shows that V is kept. Conditional moves are run after compares that set and that clear Z, which tells a passing condition from a failing one, including a failing move with S set. Random instructions, some from other classes, are checked against a bench model that carries the flags from one instruction to the next.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    localparam int XLEN   = 32;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 9;
    localparam int AMT_W  = 5;
    localparam int COND_W = 4;
    localparam int OPC_W  = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic              is_dp;
        logic              imm_form;
        alu_op_e           op;
        logic              set_flags;
        logic [COND_W-1:0] cc;
        logic [REG_W-1:0]  rd;
        logic [AMT_W-1:0]  amt;
        logic              reg_amt;
        shift_kind_e       sh;
        logic [IMM_W-1:0]  imm;
    } dp_fields_t;

    function automatic logic op_is_test(logic [OPC_W-1:0] op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_move(logic [OPC_W-1:0] op);
        return (op == OP_MOV) || (op == OP_MVN);
    endfunction

    function automatic logic op_is_logical(logic [OPC_W-1:0] op);
        case (op)
            OP_AND, OP_EOR, OP_TST, OP_TEQ,
            OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic cond_met(logic [COND_W-1:0] cc, flags_t f);
        logic base;
        case (cc[3:1])
            3'd0:    base = f.z;
            3'd1:    base = f.c;
            3'd2:    base = f.n;
            3'd3:    base = f.v;
            3'd4:    base = f.c & ~f.z;
            3'd5:    base = (f.n == f.v);
            3'd6:    base = ~f.z & (f.n == f.v);
            default: base = 1'b1;
        endcase
        if (cc[3:1] == 3'd7) return 1'b1;
        return base ^ cc[0];
    endfunction

    function automatic dp_fields_t decode_dp(logic [XLEN-1:0] w);
        dp_fields_t f;
        f.is_dp     = (w[31:30] == 2'b00);
        f.imm_form  = w[29];
        f.op        = alu_op_e'(w[28:25]);
        f.set_flags = w[24];
        f.cc        = w[22:19];
        f.rd        = w[18:14];
        f.amt       = w[13:9];
        f.reg_amt   = w[5];
        f.sh        = shift_kind_e'(w[7:6]);
        f.imm       = w[8:0];
        return f;
    endfunction

endpackage

// File: rtl/dpx_operand.sv
module dpx_operand
    import dpx_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = AMT_W,
    parameter int IW = IMM_W
) (
    input  logic              imm_form,
    input  logic              reg_amt,
    input  shift_kind_e       sh,
    input  logic [AW-1:0]     amt_field,
    input  logic [IW-1:0]     imm,
    input  logic [W-1:0]      rm_val,
    input  logic [AW-1:0]     rs_amt,
    input  logic              c_in,
    output logic [W-1:0]      op2,
    output logic              carry
);

    logic [AW-1:0] amt;
    logic [W:0]    ext;
    logic [W-1:0]  imm_ext;

    always_comb begin
        amt     = reg_amt ? rs_amt : amt_field;
        imm_ext = W'(imm);
        ext     = '0;
        op2     = rm_val;
        carry   = c_in;
        if (imm_form) begin
            op2 = (imm_ext << amt_field) | (imm_ext >> (W - int'(amt_field)));
        end else if (amt != '0) begin
            case (sh)
                SH_LSL: begin
                    ext   = {1'b0, rm_val} << amt;
                    op2   = ext[W-1:0];
                    carry = ext[W];
                end
                SH_LSR: begin
                    ext   = {rm_val, 1'b0} >> amt;
                    op2   = ext[W:1];
                    carry = ext[0];
                end
                SH_ASR: begin
                    ext   = $signed({rm_val, 1'b0}) >>> amt;
                    op2   = ext[W:1];
                    carry = ext[0];
                end
                default: begin
                    op2   = (rm_val >> amt) | (rm_val << (W - int'(amt)));
                    carry = op2[W-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
    import dpx_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          shc,
    input  flags_t        fl_in,
    output logic [W-1:0]  result,
    output flags_t        fl_out
);

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         cin;
    logic         arith;
    logic [W:0]   sum;

    always_comb begin
        x     = a;
        y     = b;
        cin   = 1'b0;
        arith = 1'b1;
        case (op)
            OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1; end
            OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
            OP_ADD, OP_CMN: ;
            OP_ADC:         cin = fl_in.c;
            OP_SBC:         begin y = ~b; cin = fl_in.c; end
            OP_RSC:         begin x = b; y = ~a; cin = fl_in.c; end
            default:        arith = 1'b0;
        endcase
        sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};

        case (op)
            OP_AND, OP_TST: result = a & b;
            OP_EOR, OP_TEQ: result = a ^ b;
            OP_ORR:         result = a | b;
            OP_MOV:         result = b;
            OP_BIC:         result = a & ~b;
            OP_MVN:         result = ~b;
            default:        result = sum[W-1:0];
        endcase

        fl_out.n = result[W-1];
        fl_out.z = (result == '0);
        fl_out.c = arith ? sum[W] : shc;
        fl_out.v = arith ? ((x[W-1] == y[W-1]) && (sum[W-1] != x[W-1])) : fl_in.v;
    end

endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
    import dpx_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   instr,
    input  logic [W-1:0]      rn_val,
    input  logic [W-1:0]      rm_val,
    input  logic [W-1:0]      rs_val,
    output logic              res_valid,
    output logic              res_write,
    output logic [REG_W-1:0]  res_rd,
    output logic [W-1:0]      res_data,
    output logic [3:0]        flags_o
);

    dp_fields_t   fld;
    flags_t       flags_q;
    flags_t       alu_flags;
    logic [W-1:0] op2;
    logic         sh_carry;
    logic [W-1:0] alu_res;
    logic         accept;
    logic         cond_ok;
    logic         commit;
    logic         unused_bits;

    assign fld         = decode_dp(instr);
    assign accept      = in_valid && fld.is_dp;
    assign cond_ok     = !op_is_move(fld.op) || cond_met(fld.cc, flags_q);
    assign commit      = accept && cond_ok;
    assign unused_bits = ^{instr[23], instr[8], rs_val[W-1:AMT_W]};

    dpx_operand #(.W(W), .AW(AMT_W), .IW(IMM_W)) u_operand (
        .imm_form  (fld.imm_form),
        .reg_amt   (fld.reg_amt),
        .sh        (fld.sh),
        .amt_field (fld.amt),
        .imm       (fld.imm),
        .rm_val    (rm_val),
        .rs_amt    (rs_val[AMT_W-1:0]),
        .c_in      (flags_q.c),
        .op2       (op2),
        .carry     (sh_carry)
    );

    dpx_alu #(.W(W)) u_alu (
        .op     (fld.op),
        .a      (rn_val),
        .b      (op2),
        .shc    (sh_carry),
        .fl_in  (flags_q),
        .result (alu_res),
        .fl_out (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= '0;
            res_valid <= 1'b0;
            res_write <= 1'b0;
            res_rd    <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= accept;
            res_write <= commit && !op_is_test(fld.op);
            if (accept) begin
                res_rd   <= fld.rd;
                res_data <= alu_res;
            end
            if (commit && fld.set_flags) begin
                flags_q <= alu_flags;
            end
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/dpx_checker.sv
module dpx_checker
    import dpx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [XLEN-1:0]  instr,
    input logic             res_valid,
    input logic             res_write,
    input logic [3:0]       flags_o
);

    logic dp_in;
    assign dp_in = in_valid && (instr[31:30] == 2'b00);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (flags_o == 4'd0 && !res_valid && !res_write)); // R11

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        dp_in |=> res_valid); // R1

    AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        res_write |-> res_valid); // R1

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !dp_in |=> !res_valid); // R12

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (dp_in && instr[28:27] == 2'b10) |=> !res_write); // R6

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(dp_in && instr[24]) |=> $stable(flags_o)); // R7

    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
        (dp_in && instr[24] && op_is_logical(instr[28:25])) |=> (flags_o[0] == $past(flags_o[0]))); // R8

endmodule

bind dp_exec_unit dpx_checker u_dpx_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .res_valid (res_valid),
    .res_write (res_write),
    .flags_o   (flags_o)
);

// File: tb/dp_exec_unit_tb.sv
`timescale 1ns/1ps
module dp_exec_unit_tb;

    typedef struct packed {
        logic        valid;
        logic        write;
        logic [3:0]  fl;
        logic [31:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rn_val = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic        res_valid;
    logic        res_write;
    logic [4:0]  res_rd;
    logic [31:0] res_data;
    logic [3:0]  flags_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [3:0] mfl = 4'd0;

    always #5 clk = ~clk;

    dp_exec_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .rn_val(rn_val), .rm_val(rm_val), .rs_val(rs_val),
        .res_valid(res_valid), .res_write(res_write), .res_rd(res_rd),
        .res_data(res_data), .flags_o(flags_o)
    );

    function automatic bit cond_ok(input logic [3:0] cc, input logic [3:0] fl);
        bit n = fl[3], z = fl[2], c = fl[1], v = fl[0];
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic exp_t model(input logic [31:0] ins, input logic [31:0] a,
                                   input logic [31:0] m, input logic [31:0] s,
                                   input logic [3:0] fl);
        exp_t e;
        logic [31:0] b, x;
        logic [63:0] w;
        logic sc, cin, nc, nv, arith, pass;
        int amt;
        longint u, sg;
        logic [3:0] op;
        e = '0;
        e.fl = fl;
        e.valid = (ins[31:30] == 2'b00);
        if (!e.valid) return e;
        op  = ins[28:25];
        cin = fl[1];
        sc  = cin;
        if (ins[29]) begin
            x = {23'd0, ins[8:0]};
            w = {x, x} << ins[13:9];
            b = w[63:32];
        end else begin
            amt = ins[5] ? int'(s[4:0]) : int'(ins[13:9]);
            b = m;
            if (amt != 0) begin
                case (ins[7:6])
                    2'b00: begin w = {32'd0, m} << amt; b = w[31:0]; sc = w[32]; end
                    2'b01: begin w = {m, 32'd0} >> amt; b = w[63:32]; sc = w[31]; end
                    2'b10: begin w = $signed({m, 32'd0}) >>> amt; b = w[63:32]; sc = w[31]; end
                    default: begin w = {m, m} >> amt; b = w[31:0]; sc = b[31]; end
                endcase
            end
        end
        arith = 1'b1;
        u = 0; sg = 0;
        case (op)
            4'd2, 4'd10: begin u = longint'(a) - longint'(b); sg = longint'($signed(a)) - longint'($signed(b)); end
            4'd3:        begin u = longint'(b) - longint'(a); sg = longint'($signed(b)) - longint'($signed(a)); end
            4'd4, 4'd11: begin u = longint'(a) + longint'(b); sg = longint'($signed(a)) + longint'($signed(b)); end
            4'd5:        begin u = longint'(a) + longint'(b) + cin; sg = longint'($signed(a)) + longint'($signed(b)) + cin; end
            4'd6:        begin u = longint'(a) - longint'(b) - (1 - cin); sg = longint'($signed(a)) - longint'($signed(b)) - (1 - cin); end
            4'd7:        begin u = longint'(b) - longint'(a) - (1 - cin); sg = longint'($signed(b)) - longint'($signed(a)) - (1 - cin); end
            default:     arith = 1'b0;
        endcase
        case (op)
            4'd0, 4'd8:  e.data = a & b;
            4'd1, 4'd9:  e.data = a ^ b;
            4'd12:       e.data = a | b;
            4'd13:       e.data = b;
            4'd14:       e.data = a & ~b;
            4'd15:       e.data = ~b;
            default:     e.data = u[31:0];
        endcase
        if (arith) begin
            if (op == 4'd4 || op == 4'd5 || op == 4'd11) nc = (u > 64'sh0FFFFFFFF);
            else nc = (u >= 0);
            nv = (sg > 64'sh07FFFFFFF) || (sg < -64'sh080000000);
        end else begin
            nc = sc;
            nv = fl[0];
        end
        pass = !(op == 4'd13 || op == 4'd15) || cond_ok(ins[22:19], fl);
        e.write = pass && !(op >= 4'd8 && op <= 4'd11);
        if (pass && ins[24]) e.fl = {e.data[31], e.data == 32'd0, nc, nv};
        return e;
    endfunction

    function automatic logic [31:0] rform(input int op, input bit s, input int rn, input int rd,
                                          input int amt, input int sh, input bit sel);
        return {3'b000, 4'(op), s, 5'(rn), 5'(rd), 5'(amt), 1'b0, 2'(sh), sel, 5'd2};
    endfunction

    function automatic logic [31:0] iform(input int op, input bit s, input int rn, input int rd,
                                          input int rot, input int imm);
        return {3'b001, 4'(op), s, 5'(rn), 5'(rd), 5'(rot), 9'(imm)};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] m,
                       input logic [31:0] s, input string tag);
        exp_t e;
        @(negedge clk);
        instr = ins; rn_val = a; rm_val = m; rs_val = s; in_valid = 1'b1;
        e = model(ins, a, m, s, mfl);
        @(negedge clk);
        in_valid = 1'b0;
        check(res_valid == e.valid, tag, "res_valid", 32'(res_valid), 32'(e.valid));
        if (e.valid) begin
            check(res_write == e.write, tag, "res_write", 32'(res_write), 32'(e.write));
            check(res_rd == ins[18:14], tag, "res_rd", 32'(res_rd), 32'(ins[18:14]));
            check(res_data == e.data, tag, "res_data", res_data, e.data);
        end
        check(flags_o == e.fl, tag, "flags", 32'(flags_o), 32'(e.fl));
        mfl = e.fl;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        check(flags_o == 4'd0, "R11", "flags after reset", 32'(flags_o), 0);
        check(res_valid == 1'b0, "R11", "res_valid after reset", 32'(res_valid), 0);
        check(res_write == 1'b0, "R11", "res_write after reset", 32'(res_write), 0);
        rst = 1'b0;

        // R2: rotated constants, one wrapping past bit 31
        run(iform(13, 1, 14, 3, 4, 9'h1FF), 0, 0, 0, "R2");
        run(iform(13, 0, 14, 4, 30, 9'h1FF), 0, 0, 0, "R2");
        run(iform(4, 1, 0, 6, 0, 9'h155), 32'h10, 0, 0, "R2");

        // R9: signed overflow, then equal subtract
        run(rform(4, 1, 1, 5, 0, 0, 0), 32'h7FFFFFFF, 32'h1, 0, "R9");
        // R8: logical op right after overflow keeps V
        run(rform(0, 1, 1, 7, 0, 0, 0), 32'hF0F0F0F0, 32'h8000FF00, 0, "R8");
        run(rform(2, 1, 1, 8, 0, 0, 0), 32'h1234, 32'h1234, 0, "R9");
        run(rform(2, 1, 1, 8, 0, 0, 0), 32'h1, 32'h2, 0, "R9");

        // R6: compare and test never write
        run(rform(10, 1, 1, 9, 0, 0, 0), 32'h5, 32'h9, 0, "R6");
        run(rform(8, 1, 1, 9, 0, 0, 0), 32'hFF, 32'h0F, 0, "R6");

        // R10: conditional moves, Z currently clear
        run(rform(10, 1, 1, 9, 0, 0, 0), 32'h5, 32'h9, 0, "R10");
        run(rform(13, 1, 0, 10, 0, 0, 0), 0, 32'h0, 0, "R10");
        run(rform(13, 0, 1, 11, 0, 0, 0), 0, 32'hABCD, 0, "R10");
        run(rform(15, 0, 16 + 0, 12, 0, 0, 0), 0, 32'h1, 0, "R10");
        run(rform(10, 1, 1, 9, 0, 0, 0), 32'h9, 32'h9, 0, "R10");
        run(rform(15, 1, 0, 12, 0, 0, 0), 0, 32'h1, 0, "R10");
        run(rform(13, 1, 11, 13, 0, 0, 0), 0, 32'h0, 0, "R10");

        // R3: immediate shift amounts
        run(rform(13, 1, 14, 14, 0, 1, 0), 0, 32'h80000001, 0, "R3");
        run(rform(13, 1, 14, 14, 1, 1, 0), 0, 32'h80000001, 0, "R3");
        run(rform(13, 1, 14, 14, 4, 2, 0), 0, 32'h80000018, 0, "R3");
        run(rform(13, 1, 14, 14, 4, 3, 0), 0, 32'h0000000F, 0, "R3");
        run(rform(13, 1, 14, 14, 31, 0, 0), 0, 32'h00000003, 0, "R3");
        run(rform(13, 1, 14, 14, 31, 2, 0), 0, 32'h40000000, 0, "R3");

        // R4: register-held amounts, upper bits ignored
        run(rform(13, 1, 14, 15, 0, 1, 1), 0, 32'hF000_0F00, 32'hFFFF_FF08, "R4");
        run(rform(13, 1, 14, 15, 7, 0, 1), 0, 32'h8765_4321, 32'h0000_0020, "R4");
        run(rform(13, 1, 14, 15, 0, 3, 1), 0, 32'h8765_4321, 32'h0000_0131, "R4");

        // R12: other instruction classes
        run({3'b101, 29'h0ABCDEF1}, 32'h1, 32'h2, 0, "R12");
        run({3'b010, 4'd4, 1'b1, 24'hFFFFFF}, 32'h7FFFFFFF, 32'h1, 0, "R12");

        // R7: S clear leaves flags alone
        run(rform(4, 0, 1, 16, 0, 0, 0), 32'h7FFFFFFF, 32'h1, 0, "R7");
        run(rform(2, 0, 1, 16, 0, 0, 0), 32'h3, 32'h3, 0, "R7");

        // R5: every opcode over fixed operands, both carry states
        for (int op = 0; op < 16; op++) begin
            run(rform(op, 1, 14, 17, 0, 0, 0), 32'h80000001, 32'h7FFFFFFF, 0, "R5");
            run(rform(op, 1, 14, 18, 0, 0, 0), 32'h00000000, 32'h00000000, 0, "R5");
        end

        // R1: idle cycle produces no result
        @(negedge clk);
        @(negedge clk);
        check(res_valid == 1'b0, "R1", "idle res_valid", 32'(res_valid), 0);
        check(res_write == 1'b0, "R1", "idle res_write", 32'(res_write), 0);
        check(flags_o == mfl, "R1", "idle flags", 32'(flags_o), 32'(mfl));

        // R5: random mix, mostly data-processing
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins;
            ins = $urandom;
            if ($urandom_range(9) != 0) ins[31:30] = 2'b00;
            run(ins, $urandom, $urandom, $urandom, "R5");
        end

        // R11: reset in the middle of traffic
        @(negedge clk);
        instr = rform(4, 1, 1, 3, 0, 0, 0); rn_val = 32'hFFFFFFFF; rm_val = 32'h1; in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(flags_o == 4'd0, "R11", "flags after mid reset", 32'(flags_o), 0);
        check(res_valid == 1'b0, "R11", "res_valid after mid reset", 32'(res_valid), 0);
        rst = 1'b0;
        mfl = 4'd0;
        run(rform(13, 1, 2, 4, 0, 0, 0), 0, 32'h5, 0, "R11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule